// File: doc/BRIEF.md
# Flash Command Guard

This block sits between the special-register write bus of an 8-bit processor and a flash memory macro. Software writes a page number, a control byte and a one-byte command code. The guard turns each legal command into a single-cycle request toward the flash side. Every other command attempt is turned away.

Erase needs a separate arming write before the magic code, and that arming is used up by the attempt. A page erase needs the page register written again. A mass erase needs the mass-erase enable written again, and the debug-port enable input must be high. Data-store cycles from the processor go to RAM unless the one-shot program-write enable is set. In that case a single store becomes a byte-program request.

A security bit can be set but never cleared, except by reset. While it is set, page zero is locked against page erase and byte programming, so only a mass erase can clear it. Any refused attempt raises a sticky error flag, and reading the status register clears that flag.

Top module: `flash_guard`

## Requirements
- R1: After reset all three request outputs, `fl_addr`, `fl_data` and `stat_rdata` are zero.
- R2: Writing the page register (`reg_sel`=1) arms a page erase and takes the page number from data bits 7:1, ignoring bit 0. A later command write (`reg_sel`=0) of 0x55 then pulses `fl_page_erase` on the cycle after the write, with `fl_addr` = page number shifted left by 9. That acceptance clears the page register and disarms it, so a repeated 0x55 without a new page write is refused. A refused page erase leaves the arming in place.
- R3: A command write of 0xAA pulses `fl_mass_erase` on the cycle after the write, with `fl_addr` = 0. This happens only when the mass-erase enable (control bit 1) is set and `dbg_port_en` is high at the command write.
- R4: A command write of any code other than 0x55 or 0xAA has no effect. It produces no request, no error, and no change to the status bits.
- R5: A 0xAA attempt without the mass-erase enable, or with `dbg_port_en` low, is refused. The mass-erase enable clears after every 0xAA attempt, whether it is accepted or refused.
- R6: With the program-write enable (control bit 0) clear, a store cycle raises `ram_we` in the same cycle. With the enable set, `ram_we` stays low, and `fl_program` pulses on the next cycle carrying the store address and data. The enable then clears after that store, whether it is accepted or refused. A control write in the same cycle that is itself taken wins over this clearing.
- R7: A control write does not change the program-write enable while `int_en` is high. The other control bits are still written.
- R8: Writing control bit 2 as 1 sets the security bit. Writing it as 0 never clears it; only reset clears it.
- R9: While the security bit is set, a page erase of page zero and a store into page zero (address bits 15:9 all zero) are refused. Mass erase and other pages are still accepted.
- R10: An erase command or program store is refused while `flash_busy` is high. It is also refused in the cycle right after a request pulse.
- R11: The status register reads bit0 = program-write enable, bit1 = mass-erase enable, bit2 = security, bit3 = error, bit4 = page armed, and zero in the other bits. Any refused attempt sets the error bit. A status read (`stat_rd`) clears it, but a refusal in the same cycle keeps it set.
- R12: A program store that coincides with a 0x55 or 0xAA command write is refused. The command is judged on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 command, 1 page, 2 control, 3 unused |
| reg_wdata | input | 8 | Register write data |
| stat_rd | input | 1 | Status read strobe (clears error) |
| stat_rdata | output | 8 | Live status view |
| st_valid | input | 1 | Processor data-store cycle |
| st_addr | input | ADDR_W | Store address |
| st_data | input | 8 | Store data |
| ram_we | output | 1 | Store routed to RAM |
| dbg_port_en | input | 1 | Debug port enabled |
| int_en | input | 1 | Global interrupt enable active |
| flash_busy | input | 1 | Flash side busy |
| fl_page_erase | output | 1 | Page-erase request pulse |
| fl_mass_erase | output | 1 | Mass-erase request pulse |
| fl_program | output | 1 | Byte-program request pulse |
| fl_addr | output | ADDR_W | Request address |
| fl_data | output | 8 | Program data |

## Verification
Directed sequences cover each gating condition alone. These include a missing arming write, a low debug enable, a busy flash, the cycle just after a pulse, and page zero under security. Each is paired with an otherwise identical accepted case, so that a refusal can be traced to exactly one condition. Non-magic codes separate a decoder that matches whole bytes from one that checks only some bits. Page bytes with bit 0 set show that bit 0 is ignored. Several thousand random cycles then mix register writes, stores, status reads, busy and interrupt-enable changes against a bench model of the rules, which exposes wrong priorities between simultaneous events.

// File: rtl/flg_pkg.sv
package flg_pkg;
   typedef enum logic [1:0] {
      SEL_CMD  = 2'd0,
      SEL_PAGE = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   localparam logic [7:0] CODE_PAGE_ERASE = 8'h55;
   localparam logic [7:0] CODE_MASS_ERASE = 8'hAA;

   localparam int CTL_PWE = 0;
   localparam int CTL_MEE = 1;
   localparam int CTL_SEC = 2;
endpackage

// File: rtl/flg_check.sv
module flg_check #(
   parameter int PG_W = 7
) (
   input  logic            cmd_wr,
   input  logic [7:0]      cmd_code,
   input  logic            pwe,
   input  logic            mee,
   input  logic            armed,
   input  logic            secure,
   input  logic            dbg_en,
   input  logic            blocked,
   input  logic [PG_W-1:0] page_num,
   input  logic            st_valid,
   input  logic [PG_W-1:0] st_page,
   output logic            pe_ok,
   output logic            me_ok,
   output logic            pg_ok,
   output logic            me_try,
   output logic            pg_try,
   output logic            refuse
);
   import flg_pkg::*;

   logic pe_try;
   logic pe_lock;
   logic pg_lock;

   always_comb begin
      pe_try  = cmd_wr && (cmd_code == CODE_PAGE_ERASE);
      me_try  = cmd_wr && (cmd_code == CODE_MASS_ERASE);
      pg_try  = st_valid && pwe;
      // page zero lock while secured (R9)
      pe_lock = secure && (page_num == '0);
      pg_lock = secure && (st_page == '0);
      pe_ok   = pe_try && !blocked && armed && !pe_lock;
      me_ok   = me_try && !blocked && mee && dbg_en;
      // a coinciding erase attempt wins over a store (R12)
      pg_ok   = pg_try && !blocked && !pe_try && !me_try && !pg_lock;
      refuse  = (pe_try && !pe_ok) || (me_try && !me_ok) || (pg_try && !pg_ok);
   end
endmodule

// File: rtl/flg_regs.sv
module flg_regs #(
   parameter int PG_W         = 7,
   parameter bit HAS_SECURITY = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            page_wr,
   input  logic [PG_W-1:0] page_in,
   input  logic            ctrl_wr,
   input  logic            pwe_in,
   input  logic            mee_in,
   input  logic            sec_in,
   input  logic            int_en,
   input  logic            stat_rd,
   input  logic            pe_ok,
   input  logic            me_try,
   input  logic            pg_try,
   input  logic            refuse,
   output logic            pwe,
   output logic            mee,
   output logic            armed,
   output logic [PG_W-1:0] page_num,
   output logic            secure,
   output logic            err
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page_num <= '0;
         armed    <= 1'b0;
         mee      <= 1'b0;
         pwe      <= 1'b0;
         err      <= 1'b0;
      end else begin
         if (page_wr) begin
            page_num <= page_in;
            armed    <= 1'b1;
         end else if (pe_ok) begin
            page_num <= '0;
            armed    <= 1'b0;
         end
         if (ctrl_wr)     mee <= mee_in;
         else if (me_try) mee <= 1'b0;
         if (ctrl_wr && !int_en) pwe <= pwe_in;
         else if (pg_try)        pwe <= 1'b0;
         if (refuse)       err <= 1'b1;
         else if (stat_rd) err <= 1'b0;
      end
   end

   generate
      if (HAS_SECURITY) begin : g_sec
         logic sec_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                sec_q <= 1'b0;
            else if (ctrl_wr && sec_in) sec_q <= 1'b1;
         end
         assign secure = sec_q;

         assert_secure_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> !$fell(sec_q));
      end else begin : g_nosec
         assign secure = 1'b0;
      end
   endgenerate

   assert_pwe_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $rose(pwe)) |-> !$past(int_en));
   assert_mee_spent_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(me_try)) |-> !mee);
   assert_err_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(refuse)) |-> err);
endmodule

// File: rtl/flash_guard.sv
module flash_guard #(
   parameter int ADDR_W       = 16,
   parameter int PAGE_LOG2    = 9,
   parameter bit HAS_SECURITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_sel,
   input  logic [7:0]        reg_wdata,
   input  logic              stat_rd,
   output logic [7:0]        stat_rdata,
   input  logic              st_valid,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [7:0]        st_data,
   output logic              ram_we,
   input  logic              dbg_port_en,
   input  logic              int_en,
   input  logic              flash_busy,
   output logic              fl_page_erase,
   output logic              fl_mass_erase,
   output logic              fl_program,
   output logic [ADDR_W-1:0] fl_addr,
   output logic [7:0]        fl_data
);
   import flg_pkg::*;

   localparam int PG_W = ADDR_W - PAGE_LOG2;

   generate
      if (PAGE_LOG2 < 1 || PG_W < 1 || PG_W > 7) begin : g_bad_geometry
         $error("flash_guard: page number must be 1..7 bits wide");
      end
   endgenerate

   reg_sel_e        sel;
   logic            cmd_wr, page_wr, ctrl_wr;
   logic            pwe, mee, armed, secure, err;
   logic [PG_W-1:0] page_num;
   logic            pe_ok, me_ok, pg_ok, me_try, pg_try, refuse;
   logic            blocked;

   assign sel     = reg_sel_e'(reg_sel);
   assign cmd_wr  = reg_wr && (sel == SEL_CMD);
   assign page_wr = reg_wr && (sel == SEL_PAGE);
   assign ctrl_wr = reg_wr && (sel == SEL_CTRL);
   // the cycle holding a request pulse counts as busy (R10)
   assign blocked = flash_busy || fl_page_erase || fl_mass_erase || fl_program;

   flg_regs #(.PG_W(PG_W), .HAS_SECURITY(HAS_SECURITY)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .page_wr  (page_wr),
      .page_in  (reg_wdata[PG_W:1]),
      .ctrl_wr  (ctrl_wr),
      .pwe_in   (reg_wdata[CTL_PWE]),
      .mee_in   (reg_wdata[CTL_MEE]),
      .sec_in   (reg_wdata[CTL_SEC]),
      .int_en   (int_en),
      .stat_rd  (stat_rd),
      .pe_ok    (pe_ok),
      .me_try   (me_try),
      .pg_try   (pg_try),
      .refuse   (refuse),
      .pwe      (pwe),
      .mee      (mee),
      .armed    (armed),
      .page_num (page_num),
      .secure   (secure),
      .err      (err)
   );

   flg_check #(.PG_W(PG_W)) u_check (
      .cmd_wr   (cmd_wr),
      .cmd_code (reg_wdata),
      .pwe      (pwe),
      .mee      (mee),
      .armed    (armed),
      .secure   (secure),
      .dbg_en   (dbg_port_en),
      .blocked  (blocked),
      .page_num (page_num),
      .st_valid (st_valid),
      .st_page  (st_addr[ADDR_W-1:PAGE_LOG2]),
      .pe_ok    (pe_ok),
      .me_ok    (me_ok),
      .pg_ok    (pg_ok),
      .me_try   (me_try),
      .pg_try   (pg_try),
      .refuse   (refuse)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fl_page_erase <= 1'b0;
         fl_mass_erase <= 1'b0;
         fl_program    <= 1'b0;
         fl_addr       <= '0;
         fl_data       <= '0;
      end else begin
         fl_page_erase <= pe_ok;
         fl_mass_erase <= me_ok;
         fl_program    <= pg_ok;
         if (pe_ok)      fl_addr <= {page_num, {PAGE_LOG2{1'b0}}};
         else if (pg_ok) fl_addr <= st_addr;
         else            fl_addr <= '0;
         fl_data <= pg_ok ? st_data : 8'h00;
      end
   end

   assign ram_we     = st_valid && !pwe;
   assign stat_rdata = {3'b000, armed, err, secure, mee, pwe};

   assert_req_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && (fl_page_erase || fl_mass_erase || fl_program))
         |-> (!$past(flash_busy) && !$past(fl_page_erase || fl_mass_erase || fl_program)));
   assert_mass_dbg_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && fl_mass_erase) |-> $past(dbg_port_en));
   assert_page0_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && (fl_program || fl_page_erase) && (fl_addr[ADDR_W-1:PAGE_LOG2] == '0))
         |-> !$past(secure));
   assert_one_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fl_page_erase, fl_mass_erase, fl_program}));
endmodule

// File: tb/flash_guard_test.sv
module flash_guard_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [7:0]  reg_wdata = 8'h00;
   logic        stat_rd = 1'b0;
   logic [7:0]  stat_rdata;
   logic        st_valid = 1'b0;
   logic [15:0] st_addr = 16'h0;
   logic [7:0]  st_data = 8'h00;
   logic        ram_we;
   logic        dbg_port_en = 1'b0;
   logic        int_en = 1'b0;
   logic        flash_busy = 1'b0;
   logic        fl_page_erase, fl_mass_erase, fl_program;
   logic [15:0] fl_addr;
   logic [7:0]  fl_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // bench model of the requirements
   logic       m_pwe = 0, m_mee = 0, m_arm = 0, m_sec = 0, m_err = 0, m_req = 0;
   logic [6:0] m_page = '0;
   logic       g_dbg = 0, g_ie = 0, g_busy = 0;

   always #2 clk = ~clk;

   flash_guard uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .stat_rd(stat_rd), .stat_rdata(stat_rdata), .st_valid(st_valid), .st_addr(st_addr),
      .st_data(st_data), .ram_we(ram_we), .dbg_port_en(dbg_port_en), .int_en(int_en),
      .flash_busy(flash_busy), .fl_page_erase(fl_page_erase), .fl_mass_erase(fl_mass_erase),
      .fl_program(fl_program), .fl_addr(fl_addr), .fl_data(fl_data)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_status();
      return {3'b000, m_arm, m_err, m_sec, m_mee, m_pwe};
   endfunction

   task automatic step(input string tag, input logic wr, input logic [1:0] sel,
                       input logic [7:0] wd, input logic rd, input logic sv,
                       input logic [15:0] sa, input logic [7:0] sd);
      logic blk, is_pe, is_me, pgt, e_pe, e_me, e_pg, rf;
      logic [15:0] e_addr;
      logic [7:0]  e_data;
      @(negedge clk);
      reg_wr = wr; reg_sel = sel; reg_wdata = wd; stat_rd = rd;
      st_valid = sv; st_addr = sa; st_data = sd;
      dbg_port_en = g_dbg; int_en = g_ie; flash_busy = g_busy;
      #1;
      if (sv) chk({tag, " R6 ram_we"}, 64'(ram_we), 64'(!m_pwe));
      blk   = g_busy | m_req;
      is_pe = wr && sel == 2'd0 && wd == 8'h55;
      is_me = wr && sel == 2'd0 && wd == 8'hAA;
      pgt   = sv && m_pwe;
      e_pe  = is_pe && !blk && m_arm && !(m_sec && m_page == 7'd0);
      e_me  = is_me && !blk && m_mee && g_dbg;
      e_pg  = pgt && !blk && !is_pe && !is_me && !(m_sec && sa[15:9] == 7'd0);
      rf    = (is_pe && !e_pe) || (is_me && !e_me) || (pgt && !e_pg);
      e_addr = e_pe ? {m_page, 9'd0} : (e_pg ? sa : 16'h0);
      e_data = e_pg ? sd : 8'h00;
      if (wr && sel == 2'd1) begin m_page = wd[7:1]; m_arm = 1; end
      else if (e_pe) begin m_page = '0; m_arm = 0; end
      if (wr && sel == 2'd2) m_mee = wd[1];
      else if (is_me) m_mee = 0;
      if (wr && sel == 2'd2 && !g_ie) m_pwe = wd[0];
      else if (pgt) m_pwe = 0;
      if (wr && sel == 2'd2 && wd[2]) m_sec = 1;
      if (rf) m_err = 1;
      else if (rd) m_err = 0;
      m_req = e_pe | e_me | e_pg;
      @(posedge clk);
      #1;
      chk({tag, " requests"}, {fl_page_erase, fl_mass_erase, fl_program, fl_addr, fl_data},
          {e_pe, e_me, e_pg, e_addr, e_data});
      chk({tag, " status"}, 64'(stat_rdata), 64'(exp_status()));
   endtask

   task automatic wreg(input string tag, input logic [1:0] sel, input logic [7:0] wd);
      step(tag, 1'b1, sel, wd, 1'b0, 1'b0, 16'h0, 8'h00);
   endtask
   task automatic store(input string tag, input logic [15:0] a, input logic [7:0] d);
      step(tag, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, a, d);
   endtask
   task automatic idle(input string tag);
      step(tag, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 16'h0, 8'h00);
   endtask
   task automatic rdst(input string tag);
      step(tag, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 16'h0, 8'h00);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(4 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 requests after reset", {fl_page_erase, fl_mass_erase, fl_program, fl_addr, fl_data}, 64'h0);
      chk("R1 status after reset", 64'(stat_rdata), 64'h0);

      // R4 non-magic codes
      wreg("R4 code 0x12", 2'd0, 8'h12);
      wreg("R4 code 0x54", 2'd0, 8'h54);
      wreg("R4 code 0xAB", 2'd0, 8'hAB);
      chk("R4 no error", 64'(stat_rdata[3]), 64'h0);

      // R2 page erase, bit 0 ignored
      wreg("R2 page write", 2'd1, 8'h0B);
      chk("R2 armed bit", 64'(stat_rdata[4]), 64'h1);
      wreg("R2 page erase", 2'd0, 8'h55);
      chk("R2 page address", 64'(fl_addr), 64'h0A00);
      idle("R2 gap");
      wreg("R2 repeat refused", 2'd0, 8'h55);
      chk("R11 error set", 64'(stat_rdata[3]), 64'h1);
      rdst("R11 read clears");
      chk("R11 error cleared", 64'(stat_rdata[3]), 64'h0);

      // R5 / R3 mass erase gating
      g_dbg = 1'b1;
      wreg("R5 mass without enable", 2'd0, 8'hAA);
      wreg("R5 enable", 2'd2, 8'h02);
      g_dbg = 1'b0;
      wreg("R5 mass with debug low", 2'd0, 8'hAA);
      chk("R5 enable spent", 64'(stat_rdata[1]), 64'h0);
      g_dbg = 1'b1;
      wreg("R3 enable", 2'd2, 8'h02);
      wreg("R3 mass erase", 2'd0, 8'hAA);
      chk("R3 mass pulse", 64'(fl_mass_erase), 64'h1);
      rdst("R11 clear");

      // R6 program and ram routing
      wreg("R6 set pwe", 2'd2, 8'h01);
      store("R6 program", 16'h1234, 8'h5A);
      chk("R6 program data", 64'(fl_data), 64'h5A);
      store("R6 back to ram", 16'h1235, 8'h11);

      // R7 pwe ignored with interrupts on
      g_ie = 1'b1;
      wreg("R7 pwe ignored", 2'd2, 8'h03);
      chk("R7 pwe stays clear", 64'(stat_rdata[0]), 64'h0);
      chk("R7 mee still written", 64'(stat_rdata[1]), 64'h1);
      g_ie = 1'b0;

      // R10 busy and pulse-cycle blocking
      wreg("R10 page write", 2'd1, 8'h08);
      g_busy = 1'b1;
      wreg("R10 busy refused", 2'd0, 8'h55);
      g_busy = 1'b0;
      chk("R10 arming kept", 64'(stat_rdata[4]), 64'h1);
      wreg("R10 page erase", 2'd0, 8'h55);
      wreg("R10 pulse cycle refused", 2'd0, 8'hAA);
      rdst("R11 clear again");

      // R11 set wins over read
      step("R11 set wins", 1'b1, 2'd0, 8'h55, 1'b1, 1'b0, 16'h0, 8'h00);
      chk("R11 error kept", 64'(stat_rdata[3]), 64'h1);
      rdst("R11 clear 3");

      // R8 security set-only
      wreg("R8 set secure", 2'd2, 8'h04);
      wreg("R8 write zero", 2'd2, 8'h00);
      chk("R8 secure kept", 64'(stat_rdata[2]), 64'h1);

      // R9 page zero lock
      wreg("R9 page zero", 2'd1, 8'h01);
      wreg("R9 page zero erase refused", 2'd0, 8'h55);
      chk("R9 no pulse", 64'(fl_page_erase), 64'h0);
      wreg("R9 page one", 2'd1, 8'h03);
      wreg("R9 page one erase", 2'd0, 8'h55);
      chk("R9 page one address", 64'(fl_addr), 64'h0200);
      wreg("R9 pwe", 2'd2, 8'h01);
      store("R9 store page zero refused", 16'h0100, 8'h77);
      wreg("R9 pwe again", 2'd2, 8'h01);
      store("R9 store page one", 16'h0300, 8'h66);
      wreg("R9 mee", 2'd2, 8'h02);
      wreg("R9 mass still allowed", 2'd0, 8'hAA);
      rdst("R11 clear 4");

      // R12 coincident command and store
      wreg("R12 pwe", 2'd2, 8'h01);
      step("R12 store with command", 1'b1, 2'd0, 8'hAA, 1'b0, 1'b1, 16'h4000, 8'h42);
      chk("R12 no program", 64'(fl_program), 64'h0);

      // random mix against the model
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] r, q;
         logic [7:0]  wd;
         r = $urandom;
         q = $urandom;
         case (r[5:4])
            2'd0: wd = 8'h55;
            2'd1: wd = 8'hAA;
            default: wd = q[23:16];
         endcase
         if (r[3:2] == 2'd2 && r[15:12] != 4'd0) wd[2] = 1'b0;
         g_dbg  = r[9] | r[10];
         g_ie   = r[11] & r[16];
         g_busy = r[17] & r[18] & r[19];
         step("random mix", r[0] | r[1], r[3:2], wd, r[8], r[7],
              (r[20] ? {7'd0, q[8:0]} : q[15:0]), q[31:24]);
      end
      g_busy = 1'b0;
      idle("final idle");
      finish_run();
   end
endmodule